// File: doc/BRIEF.md
# Video Field Ring-Buffer Sequencer

This block chooses where each captured video field goes in memory while recording runs. Memory is treated as a ring of equal-sized slots. The block keeps an index to the current slot and a count of stored fields that are complete. It drives the base byte address of the current slot to the capture datapath, together with a store-enable that marks the fields to be written. Only every second incoming field is stored, so a 60 fields/s source records at 30 fields/s and a 50 fields/s source records at 25 fields/s.

Software writes a 10-bit slot-count value N through a single 32-bit register word. The ring then has N+1 slots. When the last slot is filled, the next stored field goes back to the first slot and overwrites the oldest data. The same register word also reports the completed-field count. When the execute enable drops, the block clears the slot index, the completed-field count and the half-rate phase. The next recording therefore starts again at the first slot. In display mode the ring is held to one slot.

Top module: `vfring_seq`

## Requirements
- R1: A write (`reg_wr`=1) loads `reg_wdata[9:0]` as the slot-count value N, and the ring then holds N+1 slots: 0x000 gives 1 slot, 0x003 gives 4 slots and 0x3FF gives 1024 slots. N reads back in bits 9:0 of the register word. N is kept when the execute enable drops.
- R2: Stored fields fill slots 0, 1, …, N in that order. After the field in slot N completes, the next stored field goes to slot 0.
- R3: `slot_addr` equals `base_addr` + (current slot index × `field_bytes`), truncated to the address width.
- R4: Fields are stored at half the incoming rate. The first `field_start` after the execute enable rises selects a stored field, the next selects a skipped field, and so on. For a stored field, `store_en` goes to 1 in the cycle after its `field_start` and returns to 0 in the cycle after its `field_done`. For a skipped field, `store_en` stays 0.
- R5: The completed-field count, in bits 25:16 of the register word, rises by one (modulo 1024) on each `field_done` that arrives while `store_en` is 1. A `field_done` of a skipped field changes neither the count nor the slot index.
- R6: While `exec_en` is 0, the block clears the slot index, the completed-field count, the half-rate phase and `store_en`, and it ignores `field_start` and `field_done`.
- R7: While `disp_mode` is 1, the ring uses a single slot whatever N is, so every stored field goes to slot 0.
- R8: Bits 31:26 and 15:10 of the register word always read 0. Writes to those bits have no effect.
- R9: A new N written while recording runs is used at the next slot advance. If the current index is already at or above the new N, the next advance goes to slot 0.
- R10: `reg_rdata` is loaded with the register word in the cycle after `reg_rd` is 1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_en | input | 1 | Recording execute enable; 0 clears the sequencer state |
| disp_mode | input | 1 | Display mode; 1 forces a single slot |
| field_start | input | 1 | One-cycle strobe at the start of each incoming field |
| field_done | input | 1 | One-cycle strobe at the end of each incoming field |
| base_addr | input | ADDR_W | Byte address of slot 0 |
| field_bytes | input | ADDR_W | Size of one slot in bytes |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| slot_addr | output | ADDR_W | Base byte address of the current slot |
| store_en | output | 1 | Current field is to be written to memory |

## Verification
The current slot index is visible at once on `slot_addr`. A wrong index or a wrap that comes too early or too late therefore shows up as a wrong address on the very next stored field. The scoreboard compares that address at every stored `field_done`. A half-rate phase that is out of step shows up in the cycle after the next `field_start`, where `store_en` has the wrong value. A count that drifts, or state that is not cleared when the execute enable drops, shows up at the next register read. The bench reads the register after each scenario.

// File: rtl/vfr_pkg.sv
// Package: shared layout and types for the video field ring sequencer.
// Assumes a 32-bit register word with the count field in the upper half.
package vfr_pkg;
    localparam int REG_W   = 32;   // register word width
    localparam int CNT_LSB = 16;   // completed-field count position
    localparam int LIM_LSB = 0;    // slot-count position

    // half-rate phase: which kind of field the next start selects
    typedef enum logic {
        PH_TAKE = 1'b0,
        PH_SKIP = 1'b1
    } phase_e;
endpackage

// File: rtl/vfr_regs.sv
// Module: vfr_regs
// Holds the slot-count value and builds the registered read word.
// Assumes CNT_W <= 16 so that both fields fit their half-words.
module vfr_regs
    import vfr_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [REG_W-1:0]    reg_wdata,
    input  logic [CNT_W-1:0]    done_cnt,
    output logic [CNT_W-1:0]    slot_lim,
    output logic [REG_W-1:0]    reg_rdata
);
    logic [REG_W-1:0] word_c;
    logic             unused_wbits;

    assign unused_wbits = ^{reg_wdata[REG_W-1:LIM_LSB+CNT_W]};

    // load the slot-count field on a write
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_lim <= '0;
        else if (reg_wr)
            slot_lim <= reg_wdata[LIM_LSB +: CNT_W];
    end

    // assemble the read word with unused bits at zero
    always_comb begin
        word_c                     = '0;
        word_c[CNT_LSB +: CNT_W]   = done_cnt;
        word_c[LIM_LSB +: CNT_W]   = slot_lim;
    end

    // capture the word on a read strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= word_c;
    end

    assert_wr_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> slot_lim == $past(reg_wdata[LIM_LSB +: CNT_W]));

    assert_lim_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(slot_lim));

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

// File: rtl/vfr_field_gate.sv
// Module: vfr_field_gate
// Half-rate field selector: alternates take/skip on each field start and
// drives store_en for the duration of a taken field.
// Assumes field_start and field_done are single-cycle strobes.
module vfr_field_gate
    import vfr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic exec_en,
    input  logic field_start,
    input  logic field_done,
    output logic store_en,
    output logic advance
);
    phase_e phase_q;

    // toggle phase per field and track whether the open field is stored
    always_ff @(posedge clk) begin
        if (!rst_n || !exec_en) begin
            phase_q  <= PH_TAKE;
            store_en <= 1'b0;
        end else begin
            if (field_done)
                store_en <= 1'b0;
            if (field_start) begin
                store_en <= (phase_q == PH_TAKE);
                phase_q  <= (phase_q == PH_TAKE) ? PH_SKIP : PH_TAKE;
            end
        end
    end

    // a stored field finishing moves the ring forward
    always_comb advance = exec_en && field_done && store_en;

    assert_idle_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> !store_en);

    assert_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && field_start && phase_q == PH_SKIP) |=> !store_en);

    assert_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && field_start && phase_q == PH_TAKE) |=> store_en);

    assert_done_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (field_done && !field_start) |=> !store_en);
endmodule

// File: rtl/vfr_slot_ctr.sv
// Module: vfr_slot_ctr
// Slot index over an (N+1)-slot ring and the completed-field counter.
// Assumes advance is only raised while execution is enabled.
module vfr_slot_ctr #(
    parameter int CNT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_en,
    input  logic              disp_mode,
    input  logic              advance,
    input  logic [CNT_W-1:0]  slot_lim,
    output logic [CNT_W-1:0]  slot_idx,
    output logic [CNT_W-1:0]  done_cnt
);
    logic [CNT_W-1:0] eff_lim;
    logic             at_end;

    // display mode collapses the ring to one slot
    always_comb eff_lim = disp_mode ? '0 : slot_lim;
    // index at or past the limit means the next step wraps
    always_comb at_end  = (slot_idx >= eff_lim);

    // step the slot index and the completed count on a stored field end
    always_ff @(posedge clk) begin
        if (!rst_n || !exec_en) begin
            slot_idx <= '0;
            done_cnt <= '0;
        end else if (advance) begin
            slot_idx <= at_end ? '0 : slot_idx + 1'b1;
            done_cnt <= done_cnt + 1'b1;
        end
    end

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && advance && slot_idx >= eff_lim) |=> slot_idx == '0);

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && advance && slot_idx < eff_lim) |=> slot_idx == $past(slot_idx) + 1'b1);

    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && advance) |=> done_cnt == $past(done_cnt) + 1'b1);

    assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && !advance) |=> $stable(done_cnt) && $stable(slot_idx));

    assert_exec_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> (slot_idx == '0) && (done_cnt == '0));
endmodule

// File: rtl/vfr_addr_gen.sv
// Module: vfr_addr_gen
// Converts the slot index into a byte address: base + index * slot size.
// Assumes the product fits the address width (wraps silently otherwise).
module vfr_addr_gen #(
    parameter int CNT_W  = 10,
    parameter int ADDR_W = 32
) (
    input  logic [CNT_W-1:0]   slot_idx,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [ADDR_W-1:0]  field_bytes,
    output logic [ADDR_W-1:0]  slot_addr
);
    logic [ADDR_W-1:0] idx_ext;
    logic [ADDR_W-1:0] offset;

    // widen the index and scale it by the slot size
    always_comb begin
        idx_ext   = ADDR_W'(slot_idx);
        offset    = idx_ext * field_bytes;
        slot_addr = base_addr + offset;
    end
endmodule

// File: rtl/vfring_seq.sv
// Module: vfring_seq (top)
// Video field ring-buffer sequencer: stores every second field into an
// (N+1)-slot ring in memory and reports the completed-field count.
// Assumes one clock domain and single-cycle field strobes.
module vfring_seq
    import vfr_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exec_en,
    input  logic               disp_mode,
    input  logic               field_start,
    input  logic               field_done,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [ADDR_W-1:0]  field_bytes,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic [ADDR_W-1:0]  slot_addr,
    output logic               store_en
);
    logic [CNT_W-1:0] slot_lim;
    logic [CNT_W-1:0] slot_idx;
    logic [CNT_W-1:0] done_cnt;
    logic             advance;

    vfr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .done_cnt  (done_cnt),
        .slot_lim  (slot_lim),
        .reg_rdata (reg_rdata)
    );

    vfr_field_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .exec_en     (exec_en),
        .field_start (field_start),
        .field_done  (field_done),
        .store_en    (store_en),
        .advance     (advance)
    );

    vfr_slot_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .exec_en   (exec_en),
        .disp_mode (disp_mode),
        .advance   (advance),
        .slot_lim  (slot_lim),
        .slot_idx  (slot_idx),
        .done_cnt  (done_cnt)
    );

    vfr_addr_gen #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_addr (
        .slot_idx    (slot_idx),
        .base_addr   (base_addr),
        .field_bytes (field_bytes),
        .slot_addr   (slot_addr)
    );

    assert_disp_slot0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_mode && $past(disp_mode)) |-> slot_addr == base_addr);

    assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31:26] == '0) && (reg_rdata[15:10] == '0));
endmodule

// File: tb/tb_vfring_seq.sv
// Scoreboard bench for vfring_seq: the field driver pushes expected slot
// addresses, a negedge monitor pops and compares them on stored field ends.
module tb_vfring_seq;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          exec_en = 1'b0, disp_mode = 1'b0;
    logic          field_start = 1'b0, field_done = 1'b0;
    logic [AW-1:0] base_addr = 32'h8000_0000;
    logic [AW-1:0] field_bytes = 32'h0000_0100;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [AW-1:0] slot_addr;
    logic          store_en;

    vfring_seq dut (.*);

    always #2.5 clk = ~clk;   // 200 MHz

    int n_cmp = 0, n_bad = 0;
    logic [AW-1:0] expq [$];

    // bench model
    int m_idx = 0, m_cnt = 0, m_lim = 0;
    bit m_phase = 0;

    function automatic int eff_lim();
        return disp_mode ? 0 : m_lim;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [31:0] d);
        reg_wr = 1'b1; reg_wdata = d; cyc(1);
        reg_wr = 1'b0; m_lim = int'(d[9:0]);
    endtask

    task automatic rd_check(string req);
        reg_rd = 1'b1; cyc(1); reg_rd = 1'b0;
        check(req, reg_rdata, {6'b0, 10'(m_cnt), 6'b0, 10'(m_lim)});
    endtask

    // one incoming field: start, gap, done
    task automatic do_field(int gap);
        bit stored;
        stored = (m_phase == 0) && exec_en;
        if (exec_en) m_phase = ~m_phase;
        field_start = 1'b1; cyc(1); field_start = 1'b0;
        check("R4 store_en after start", store_en, stored);
        if (stored) expq.push_back(base_addr + AW'(m_idx) * field_bytes);
        cyc(gap);
        field_done = 1'b1; cyc(1); field_done = 1'b0;
        check("R4 store_en after done", store_en, 1'b0);
        if (stored) begin
            m_cnt = (m_cnt + 1) % 1024;
            m_idx = (m_idx >= eff_lim()) ? 0 : m_idx + 1;
        end
    endtask

    task automatic exec_cycle();
        exec_en = 1'b0; cyc(2);
        exec_en = 1'b1; cyc(1);
        m_idx = 0; m_cnt = 0; m_phase = 0;
    endtask

    // monitor: compare address on each stored field end (R2/R3)
    always @(negedge clk) begin
        if (rst_n && field_done && store_en) begin
            n_cmp++;
            if (expq.size() == 0) begin
                n_bad++;
                $display("FAIL R2/R3 unexpected store actual=0x%0h expected=none", slot_addr);
            end else begin
                logic [AW-1:0] e;
                e = expq.pop_front();
                if (slot_addr !== e) begin
                    n_bad++;
                    $display("FAIL R3 slot_addr actual=0x%0h expected=0x%0h", slot_addr, e);
                end
            end
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1; cyc(1);
        // reset state
        rd_check("R10 reset word");
        check("R6 reset store_en", store_en, 1'b0);
        check("R3 reset slot_addr", slot_addr, base_addr);

        // R8: reserved bits ignored, R1 field loaded
        wr(32'hFFFF_FFFF);
        rd_check("R8 reserved bits read 0");
        // R6: strobes ignored while exec low
        do_field(1);
        check("R6 no store while idle", store_en, 1'b0);

        // R1/R2/R4/R5: 4-slot ring, 10 fields -> 5 stored, wraps once
        wr(32'h0000_0003);
        exec_en = 1'b1; cyc(1);
        for (int i = 0; i < 10; i++) do_field(2);
        rd_check("R5 count after 5 stored");
        check("R2 index wrapped to 1", slot_addr, base_addr + field_bytes);

        // R6: execute drop clears count and index; R1 limit kept
        exec_cycle();
        rd_check("R6 count cleared, R1 limit kept");
        check("R6 slot back to 0", slot_addr, base_addr);
        for (int i = 0; i < 8; i++) do_field(1);   // idx 0..3 -> wraps to 0

        // R9: shrink limit while index past it
        for (int i = 0; i < 6; i++) do_field(1);   // idx now 3
        check("R9 index at 3", slot_addr, base_addr + 3 * field_bytes);
        wr(32'h0000_0001);
        for (int i = 0; i < 6; i++) do_field(1);   // 3 -> 0 -> 1 -> 0
        rd_check("R9 count after shrink");

        // R7: display mode forces a single slot
        exec_cycle();
        wr(32'h0000_0005);
        disp_mode = 1'b1;
        for (int i = 0; i < 6; i++) do_field(1);
        check("R7 single slot", slot_addr, base_addr);
        rd_check("R7 count in display mode");
        disp_mode = 1'b0;

        // R1/R2: single slot with N=0
        exec_cycle();
        wr(32'h0000_0000);
        for (int i = 0; i < 4; i++) do_field(0);
        check("R2 N=0 stays slot 0", slot_addr, base_addr);

        // R1/R2/R5: full 1024-slot ring, count wraps mod 1024
        exec_cycle();
        field_bytes = 32'h0000_0040;
        wr(32'h0000_03FF);
        for (int i = 0; i < 2046; i++) do_field(0);
        check("R2 at last slot", slot_addr, base_addr + 1023 * field_bytes);
        do_field(0); do_field(0);
        check("R2 1024-slot wrap", slot_addr, base_addr);
        rd_check("R5 count wraps to 0");

        // R10: rdata holds without a read strobe
        do_field(0); do_field(0);
        check("R10 rdata held", reg_rdata, {22'b0, 10'h3FF});
        rd_check("R10 rdata refreshed");

        check("scoreboard drained", expq.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule